// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when the contents of a volatile SRAM image are copied into a nonvolatile backup array, and when they are copied back. A copy into the backup array is a store. It can be started in three ways: a detected loss of supply while automatic store is enabled, a qualified pulse on a hardware store pin, or a one-cycle software request. A copy back into SRAM is a recall. It starts when the supply comes up past its trip level, or on a software request. Every store first runs a status-register write cycle. The array copy that follows it is skipped when nothing has been written to the SRAM since the last completed store.

The bus front end reads two signals from the block. The `lockout` output tells it to refuse every command. The `busy` output marks an operation in progress. The copy engine receives a request level and a direction, and the three phase lengths come from cycle-count parameters. Triggers that arrive while an operation runs are held and served once it ends. A waiting store is always served before a waiting recall.

Top module: `nvm_backup_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `copy_req`, `status_wr` and `array_modified` are 0. `lockout` is 1 until the supply has been seen above the trip level.
- R2: On the first cycle in which `vtrip_low` is sampled 0 after reset or after a supply loss, a recall is queued. The recall holds `copy_req`=1 with `copy_dir`=1 for exactly RECALL_CYC cycles. `lockout` stays 1 from the supply rise until the recall ends, and it is 0 afterwards.
- R3: `lockout` is 1 in every cycle in which `vtrip_low` is 1.
- R4: A supply loss (`vtrip_low` going from 0 to 1) queues a store only when `autostore_en` is 1. With `autostore_en`=0 no operation follows the loss.
- R5: A hardware store is queued only after `hs_pin` has been high for at least HS_MIN_CYC consecutive clock samples. A shorter pulse starts nothing, and a long pulse queues exactly one store.
- R6: Every store begins with `status_wr`=1 for exactly STATWR_CYC cycles. If `array_modified` was 1, `copy_req`=1 with `copy_dir`=0 follows for exactly STORE_CYC cycles. Otherwise the operation ends after the status write.
- R7: `array_modified` becomes 1 in the cycle after `sram_wr_accept` is 1. It is cleared when an array store completes. A write in the final store cycle wins over the clear.
- R8: `busy` stays 1 without a gap for the whole of each operation. `copy_req` implies `busy`, and `copy_req` and `status_wr` are never 1 together.
- R9: A trigger that arrives during an operation is latched and served afterwards. Between two operations served back to back, `busy` is 0 for exactly one cycle.
- R10: When a store and a recall are both waiting, the store is served first.
- R11: A one-cycle pulse on `sw_store_req` queues a store, and a one-cycle pulse on `sw_recall_req` queues a recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vtrip_low | input | 1 | Supply is below the trip level |
| autostore_en | input | 1 | Status bit enabling store on supply loss |
| hs_pin | input | 1 | Asynchronous hardware store pin |
| sw_store_req | input | 1 | Software store request, one-cycle pulse |
| sw_recall_req | input | 1 | Software recall request, one-cycle pulse |
| sram_wr_accept | input | 1 | An SRAM write was accepted this cycle |
| busy | output | 1 | A store, status write or recall is in progress |
| lockout | output | 1 | Bus front end must not acknowledge commands |
| status_wr | output | 1 | Status-register write cycle in progress |
| copy_req | output | 1 | Copy engine request, held for the array phase |
| copy_dir | output | 1 | Copy direction: 1 backup-to-SRAM, 0 SRAM-to-backup |
| array_modified | output | 1 | SRAM written since the last completed store |

## Verification
The assertions assume that `sram_wr_accept` is a qualified single-cycle event from the bus front end. They also assume that the inputs are held stable around the clock edge; only `hs_pin` is treated as asynchronous. The bench drives every input at the falling edge, and it issues SRAM writes only while the block is idle. It asserts `vtrip_low` at reset, so that the first supply rise is a real power-up. Operation lengths are checked by measuring each `busy` window against an expected-item queue.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STATWR = 2'd1,
    PH_STORE  = 2'd2,
    PH_RECALL = 2'd3
  } phase_e;

  // Width needed to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Total busy length of a store, given whether the array copy runs.
  function automatic int unsigned store_len(input int unsigned stw,
                                            input int unsigned sto,
                                            input bit          modified);
    return modified ? (stw + sto) : stw;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvm_hs_filter.sv
module nvm_hs_filter #(
  parameter int unsigned HS_MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_pin,
  output logic hs_fire
);
  localparam int unsigned CW = nvm_seq_pkg::cnt_width(HS_MIN_CYC);
  localparam logic [CW-1:0] LIM = CW'(HS_MIN_CYC);
  localparam logic [CW-1:0] HIT = CW'(HS_MIN_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          level;

  assign level = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], hs_pin};
    end
  end

  // Count consecutive high samples, saturating at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!level) begin
      run_q <= '0;
    end else if (run_q < LIM) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hs_fire = level && (run_q == HIT);

endmodule

// File: rtl/nvm_trig_latch.sv
module nvm_trig_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic vtrip_low,
  input  logic autostore_en,
  input  logic hs_fire,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic start_store,
  input  logic start_recall,
  output logic power_ok,
  output logic pend_store,
  output logic pend_recall
);
  logic power_up_ev;
  logic power_lost_ev;
  logic store_ev;
  logic recall_ev;

  assign power_up_ev   = !power_ok && !vtrip_low;
  assign power_lost_ev = power_ok && vtrip_low;
  assign store_ev      = (power_lost_ev && autostore_en) || hs_fire || sw_store_req;
  assign recall_ev     = power_up_ev || sw_recall_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_ok <= 1'b0;
    end else if (power_up_ev) begin
      power_ok <= 1'b1;
    end else if (power_lost_ev) begin
      power_ok <= 1'b0;
    end
  end

  // A new trigger in the same cycle as a start stays queued.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_store  <= 1'b0;
      pend_recall <= 1'b0;
    end else begin
      pend_store  <= (pend_store && !start_store) || store_ev;
      pend_recall <= (pend_recall && !start_recall) || recall_ev;
    end
  end

endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/nvm_backup_seq.sv
module nvm_backup_seq #(
  parameter int unsigned STATWR_CYC = 20,
  parameter int unsigned STORE_CYC  = 64,
  parameter int unsigned RECALL_CYC = 32,
  parameter int unsigned HS_MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vtrip_low,
  input  logic autostore_en,
  input  logic hs_pin,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic sram_wr_accept,
  output logic busy,
  output logic lockout,
  output logic status_wr,
  output logic copy_req,
  output logic copy_dir,
  output logic array_modified
);
  import nvm_seq_pkg::*;

  localparam int unsigned MAXC = max3(STATWR_CYC, STORE_CYC, RECALL_CYC);
  localparam int unsigned TW   = cnt_width(MAXC);
  localparam logic [TW-1:0] STW_LD = TW'(STATWR_CYC - 1);
  localparam logic [TW-1:0] STO_LD = TW'(STORE_CYC - 1);
  localparam logic [TW-1:0] RCL_LD = TW'(RECALL_CYC - 1);

  phase_e        ph_q, ph_d;
  logic          hs_fire;
  logic          power_ok;
  logic          pend_store, pend_recall;
  logic          start_store, start_recall;
  logic          phase_done;
  logic          store_done;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          am_q;

  nvm_hs_filter #(.HS_MIN_CYC(HS_MIN_CYC)) u_hs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_pin  (hs_pin),
    .hs_fire (hs_fire)
  );

  nvm_trig_latch u_trig (
    .clk           (clk),
    .rst_n         (rst_n),
    .vtrip_low     (vtrip_low),
    .autostore_en  (autostore_en),
    .hs_fire       (hs_fire),
    .sw_store_req  (sw_store_req),
    .sw_recall_req (sw_recall_req),
    .start_store   (start_store),
    .start_recall  (start_recall),
    .power_ok      (power_ok),
    .pend_store    (pend_store),
    .pend_recall   (pend_recall)
  );

  nvm_op_timer #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (phase_done)
  );

  // Stores take priority over recalls.
  assign start_store  = (ph_q == PH_IDLE) && pend_store;
  assign start_recall = (ph_q == PH_IDLE) && !pend_store && pend_recall;
  assign store_done   = (ph_q == PH_STORE) && phase_done;

  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_store) begin
          ph_d     = PH_STATWR;
          tmr_load = 1'b1;
          tmr_val  = STW_LD;
        end else if (start_recall) begin
          ph_d     = PH_RECALL;
          tmr_load = 1'b1;
          tmr_val  = RCL_LD;
        end
      end
      PH_STATWR: begin
        if (phase_done) begin
          if (am_q) begin
            ph_d     = PH_STORE;
            tmr_load = 1'b1;
            tmr_val  = STO_LD;
          end else begin
            ph_d = PH_IDLE;
          end
        end
      end
      PH_STORE:  if (phase_done) ph_d = PH_IDLE;
      PH_RECALL: if (phase_done) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  // A write in the final store cycle keeps the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      am_q <= 1'b0;
    end else if (sram_wr_accept) begin
      am_q <= 1'b1;
    end else if (store_done) begin
      am_q <= 1'b0;
    end
  end

  assign busy           = (ph_q != PH_IDLE);
  assign status_wr      = (ph_q == PH_STATWR);
  assign copy_req       = (ph_q == PH_STORE) || (ph_q == PH_RECALL);
  assign copy_dir       = (ph_q == PH_RECALL);
  assign lockout        = busy || vtrip_low || !power_ok || pend_recall;
  assign array_modified = am_q;

endmodule

// File: rtl/nvm_backup_seq_chk.sv
module nvm_backup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic vtrip_low,
  input logic sram_wr_accept,
  input logic busy,
  input logic lockout,
  input logic status_wr,
  input logic copy_req,
  input logic copy_dir,
  input logic array_modified
);

  p_lock_supply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vtrip_low |-> lockout);

  p_recall_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_req && copy_dir) |-> lockout);

  p_copy_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    copy_req |-> busy);

  p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(copy_req && status_wr));

  p_statwr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(copy_req) && !copy_dir) |-> $past(status_wr));

  p_skip_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status_wr) && !$past(array_modified)) |-> !busy);

  p_am_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_accept |=> array_modified);

  p_am_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(copy_req) && !$past(copy_dir) && !$past(sram_wr_accept)) |-> !array_modified);

endmodule

bind nvm_backup_seq nvm_backup_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .vtrip_low      (vtrip_low),
  .sram_wr_accept (sram_wr_accept),
  .busy           (busy),
  .lockout        (lockout),
  .status_wr      (status_wr),
  .copy_req       (copy_req),
  .copy_dir       (copy_dir),
  .array_modified (array_modified)
);

// File: tb/nvm_backup_seq_tb.sv
module nvm_backup_seq_tb;
  localparam int unsigned STW = 6;
  localparam int unsigned STO = 12;
  localparam int unsigned RCL = 9;
  localparam int unsigned HSM = 5;

  localparam int K_RECALL = 0;
  localparam int K_FULL   = 1;
  localparam int K_STAT   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vtrip_low = 1'b1;
  logic autostore_en = 1'b0;
  logic hs_pin = 1'b0;
  logic sw_store_req = 1'b0;
  logic sw_recall_req = 1'b0;
  logic sram_wr_accept = 1'b0;
  logic busy, lockout, status_wr, copy_req, copy_dir, array_modified;

  int n_checks = 0;
  int n_fail   = 0;
  int expq[$];
  int pulse_cnt = 0;
  int last_gap = 0;
  int idle_run = 0;
  int cur_len = 0, cur_cp = 0, cur_st = 0;
  logic cur_dir = 1'b0;
  logic prev_busy = 1'b0;

  always #10 clk = ~clk;

  nvm_backup_seq #(
    .STATWR_CYC(STW), .STORE_CYC(STO), .RECALL_CYC(RCL), .HS_MIN_CYC(HSM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .vtrip_low(vtrip_low), .autostore_en(autostore_en),
    .hs_pin(hs_pin), .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
    .sram_wr_accept(sram_wr_accept), .busy(busy), .lockout(lockout),
    .status_wr(status_wr), .copy_req(copy_req), .copy_dir(copy_dir),
    .array_modified(array_modified)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: measure each busy window and compare with the queue head.
  task automatic close_pulse();
    int k, e_len, e_cp, e_st;
    if (expq.size() == 0) begin
      chk(1'b0, "R4/R5 unexpected operation", cur_len, 0);
      return;
    end
    k = expq.pop_front();
    e_len = (k == K_RECALL) ? RCL : (k == K_FULL) ? STW + STO : STW;
    e_cp  = (k == K_RECALL) ? RCL : (k == K_FULL) ? STO : 0;
    e_st  = (k == K_RECALL) ? 0 : STW;
    chk(cur_len == e_len, (k == K_RECALL) ? "R2 recall length" : "R6 store length", cur_len, e_len);
    chk(cur_cp == e_cp, "R6/R8 copy phase length", cur_cp, e_cp);
    chk(cur_st == e_st, "R6 status write length", cur_st, e_st);
    if (e_cp != 0)
      chk(cur_dir == (k == K_RECALL), "R2/R6 copy direction", int'(cur_dir), int'(k == K_RECALL));
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!prev_busy) begin
          last_gap = idle_run;
          cur_len = 0; cur_cp = 0; cur_st = 0;
          pulse_cnt++;
        end
        cur_len++;
        if (copy_req) begin cur_cp++; cur_dir = copy_dir; end
        if (status_wr) cur_st++;
        idle_run = 0;
      end else begin
        if (prev_busy) close_pulse();
        idle_run++;
      end
      prev_busy = busy;
    end
  end

  task automatic wait_drain();
    int t = 0;
    int quiet = 0;
    while (quiet < 4 && t < 3000) begin
      @(negedge clk);
      t++;
      if (expq.size() == 0 && !busy) quiet++; else quiet = 0;
    end
    chk(t < 3000, "R9 queue drained", expq.size(), 0);
  endtask

  task automatic pulse_sw_store();
    sw_store_req = 1'b1; @(negedge clk); sw_store_req = 1'b0;
  endtask

  task automatic pulse_sw_recall();
    sw_recall_req = 1'b1; @(negedge clk); sw_recall_req = 1'b0;
  endtask

  task automatic sram_write();
    sram_wr_accept = 1'b1; @(negedge clk); sram_wr_accept = 1'b0;
  endtask

  task automatic hs_pulse(input int n);
    hs_pin = 1'b1;
    repeat (n) @(negedge clk);
    hs_pin = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    int pc;
    repeat (3) @(negedge clk);
    chk(!busy && !copy_req && !status_wr && !array_modified, "R1 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !array_modified, "R1 first cycle idle", int'(busy), 0);
    chk(lockout, "R1 lockout before supply", int'(lockout), 1);

    // R2: power-up recall
    expq.push_back(K_RECALL);
    vtrip_low = 1'b0;
    @(negedge clk);
    chk(lockout, "R2 lockout across supply rise", int'(lockout), 1);
    @(negedge clk);
    chk(lockout, "R2 lockout before recall", int'(lockout), 1);
    wait_drain();
    chk(!lockout, "R2 lockout released after recall", int'(lockout), 0);

    // R11/R6: software store with clean array, status write only
    expq.push_back(K_STAT);
    pulse_sw_store();
    wait_drain();

    // R7: write sets the flag
    sram_write();
    chk(array_modified, "R7 flag set by write", int'(array_modified), 1);

    // R5: short hardware pulse ignored
    pc = pulse_cnt;
    hs_pulse(HSM - 1);
    repeat (30) @(negedge clk);
    chk(pulse_cnt == pc && !busy, "R5 short pulse ignored", pulse_cnt - pc, 0);
    chk(array_modified, "R5 flag kept after glitch", int'(array_modified), 1);

    // R5/R6/R7: long hardware pulse -> full store, exactly one
    expq.push_back(K_FULL);
    hs_pulse(HSM + 4);
    wait_drain();
    chk(!array_modified, "R7 flag cleared by store", int'(array_modified), 0);

    // R9/R10: triggers during a store; store served before recall
    sram_write();
    expq.push_back(K_FULL);
    expq.push_back(K_STAT);
    expq.push_back(K_RECALL);
    pulse_sw_store();
    repeat (4) @(negedge clk);
    pulse_sw_recall();
    pulse_sw_store();
    wait_drain();
    chk(last_gap == 1, "R9 one idle cycle between operations", last_gap, 1);

    // R4: supply loss with auto-store disabled
    pc = pulse_cnt;
    autostore_en = 1'b0;
    vtrip_low = 1'b1;
    repeat (40) @(negedge clk);
    chk(pulse_cnt == pc, "R4 no store when disabled", pulse_cnt - pc, 0);
    chk(lockout, "R3 lockout while supply low", int'(lockout), 1);
    expq.push_back(K_RECALL);
    vtrip_low = 1'b0;
    wait_drain();

    // R4: supply loss with auto-store enabled and modified array
    autostore_en = 1'b1;
    sram_write();
    expq.push_back(K_FULL);
    vtrip_low = 1'b1;
    repeat (3) @(negedge clk);
    chk(lockout, "R3 lockout during auto-store", int'(lockout), 1);
    wait_drain();
    chk(!array_modified, "R4 auto-store cleared flag", int'(array_modified), 0);
    expq.push_back(K_RECALL);
    vtrip_low = 1'b0;
    wait_drain();
    chk(!lockout && expq.size() == 0, "R2 final state", int'(lockout), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule